// File: doc/BRIEF.md
# Quarter-Wave DDS Sine Generator

This core synthesizes a digital sine wave by direct digital synthesis. A 21-bit phase accumulator advances by an unsigned 16-bit tuning word once every four system clocks. The output frequency is therefore f_clk × word / 2^23, and the smallest nonzero frequency is the same as the frequency step, f_clk / 2^23. The top bits of the accumulator are split into three fields: a half-cycle sign, a quadrant flag and a 7-bit sample index. Only one quarter of a sine period is stored. The other three quarters are reconstructed by mirroring the index and applying the sign. The result is registered as an 8-bit sign-magnitude code, ready for an external converter.

Two clock-enable pulses are produced for neighbouring logic, one at half and one at an eighth of the system clock rate. They keep running while the core is powered down.

A mute request does not cut the waveform mid-cycle. The output completes the half period in progress and only then parks at the zero code. A later release takes effect at the next half-period boundary. A power-down request zeroes the output on the next clock, while the accumulator keeps advancing.

Top module: `dds_sine_core`

## Requirements
- R1: While `rst` is high, `dac_code` is 8'h00, the accumulator is cleared and both enable outputs are low. The first reference tick after reset therefore presents the code for phase 0, which is 8'h01.
- R2: A reference tick occurs on the 4th, 8th, 12th, ... rising edge after reset is released. On each tick the 21-bit accumulator adds `freq_word`, zero-extended to 21 bits, and wraps modulo 2^21. Between ticks the accumulator holds its value.
- R3: In the accumulator, bit 20 is the sign, bit 19 is the quadrant flag and bits 18:12 are the sample index. When the quadrant flag is 1, the index is one's-complemented before the table lookup. Bits 11:0 do not affect the output.
- R4: Quarter-table entry k (0..127) equals round(127 × sin((k + 0.5) × π / 256)).
- R5: `dac_code` is {sign, magnitude[6:0]}, where bit 7 is the sign bit and bits 6:0 are the table value. It is loaded on each reference tick from the accumulator value held before that tick's addition. Otherwise it holds, except as stated in R9.
- R6: `div2_en` is high on every second clock and `div8_en` on every eighth. `div8_en` is first high after the 7th rising edge following reset release, and it is only ever high together with `div2_en`.
- R7: While `inhibit_req` is high at a tick where the sign bit differs from its value at the previous tick, the core enters the muted state. From that tick on, `dac_code` is 8'h00. Before that boundary, the waveform continues unchanged.
- R8: While muted, the accumulator keeps advancing. Dropping `inhibit_req` resumes the waveform only at the next tick where the sign bit changes. Until then, the output stays at 8'h00.
- R9: One clock after `powerdown_req` is seen high, `dac_code` is 8'h00, and it stays there while the request is held. The accumulator and the enable outputs keep running. After release, the next tick loads the code for the advanced phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 16 | Unsigned phase increment per reference tick |
| inhibit_req | input | 1 | Mute at the next half-period boundary |
| powerdown_req | input | 1 | Force the output to zero on the next clock |
| dac_code | output | 8 | Sign-magnitude sample, sign in bit 7 |
| div2_en | output | 1 | Enable pulse at clk / 2 |
| div8_en | output | 1 | Enable pulse at clk / 8 |

## Verification
The bound checker watches four cycle-level properties on every cycle:
- the accumulator and the output hold between reference ticks;
- the output is zero after power-down;
- the output is silent whenever the muted state is set;
- the two enable pulses keep their cadence.

The actual sample values can only be shown by the bench scenarios. These include the table contents and the quadrant mirroring over a full 512-step sweep, wrap-around with the largest tuning word, and the exact tick at which muting begins and ends relative to the sign-bit boundary. A bench model of the accumulator and the mute state predicts every tick's code from the requirements.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int FREQ_W    = 16;
    localparam int ACC_W     = 21;
    localparam int IDX_W     = 7;
    localparam int MAG_W     = 7;
    localparam int FIELD_W   = IDX_W + 2;
    localparam int TBL_DEPTH = 2 ** IDX_W;
    localparam real PI       = 3.14159265358979;

    // Upper accumulator fields, most significant first
    typedef struct packed {
        logic             sign;
        logic             quad;
        logic [IDX_W-1:0] idx;
    } phase_fields_t;

    // Converter code: sign bit above the magnitude
    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } dac_code_t;

    localparam dac_code_t ZERO_CODE = '0;

    function automatic logic [MAG_W-1:0] quarter_sine(input int k);
        real amp;
        amp = real'(2 ** MAG_W - 1) *
              $sin((real'(k) + 0.5) * PI / real'(2 * TBL_DEPTH));
        return MAG_W'($rtoi(amp + 0.5));
    endfunction

endpackage

// File: rtl/dds_clk_en.sv
module dds_clk_en #(
    parameter int REF_LOG2  = 2,
    parameter int SLOW_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    output logic ref_en,
    output logic half_en,
    output logic slow_en
);
    logic [SLOW_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    always_comb begin
        ref_en  = &cnt[REF_LOG2-1:0];
        half_en = cnt[0];
        slow_en = &cnt;
    end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int FREQ_W = dds_pkg::FREQ_W,
    parameter int ACC_W  = dds_pkg::ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [FREQ_W-1:0] freq_word,
    output logic [ACC_W-1:0]  phase
);
    localparam int PAD_W = ACC_W - FREQ_W;

    always_ff @(posedge clk) begin
        if (rst)          phase <= '0;
        else if (step_en) phase <= phase + {{PAD_W{1'b0}}, freq_word};
    end
endmodule

// File: rtl/dds_quarter_lut.sv
module dds_quarter_lut
    import dds_pkg::*;
(
    input  phase_fields_t fields,
    output dac_code_t     code
);
    logic [MAG_W-1:0] rom [TBL_DEPTH];
    logic [IDX_W-1:0] addr;

    for (genvar k = 0; k < TBL_DEPTH; k++) begin : g_rom
        assign rom[k] = quarter_sine(k);
    end

    always_comb begin
        addr     = fields.quad ? ~fields.idx : fields.idx;
        code.neg = fields.sign;
        code.mag = rom[addr];
    end
endmodule

// File: rtl/dds_mute_ctrl.sv
module dds_mute_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic sign_bit,
    input  logic inhibit,
    output logic mute_next,
    output logic mute_q
);
    logic sign_q;
    logic crossing;

    always_comb begin
        crossing  = sign_bit ^ sign_q;
        mute_next = crossing ? inhibit : mute_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_q <= 1'b0;
            mute_q <= 1'b0;
        end else if (step_en) begin
            sign_q <= sign_bit;
            mute_q <= mute_next;
        end
    end
endmodule

// File: rtl/dds_sine_core.sv
module dds_sine_core
    import dds_pkg::*;
#(
    parameter int REF_LOG2  = 2,
    parameter int SLOW_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic              inhibit_req,
    input  logic              powerdown_req,
    output logic [MAG_W:0]    dac_code,
    output logic              div2_en,
    output logic              div8_en
);
    logic          ref_en;
    logic [ACC_W-1:0] phase;
    phase_fields_t fields;
    dac_code_t     lut_code;
    dac_code_t     dac_q;
    logic          mute_next;
    logic          muted_q;

    dds_clk_en #(.REF_LOG2(REF_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_clk_en (
        .clk(clk), .rst(rst), .ref_en(ref_en),
        .half_en(div2_en), .slow_en(div8_en)
    );

    dds_phase_acc #(.FREQ_W(FREQ_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .step_en(ref_en),
        .freq_word(freq_word), .phase(phase)
    );

    assign fields = phase[ACC_W-1 -: FIELD_W];

    dds_quarter_lut u_lut (.fields(fields), .code(lut_code));

    dds_mute_ctrl u_mute (
        .clk(clk), .rst(rst), .step_en(ref_en), .sign_bit(fields.sign),
        .inhibit(inhibit_req), .mute_next(mute_next), .mute_q(muted_q)
    );

    always_ff @(posedge clk) begin
        if (rst || powerdown_req) dac_q <= ZERO_CODE;
        else if (ref_en)          dac_q <= mute_next ? ZERO_CODE : lut_code;
    end

    assign dac_code = dac_q;
endmodule

// File: rtl/dds_sine_core_chk.sv
module dds_sine_core_chk #(
    parameter int ACC_W  = 21,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_en,
    input logic              powerdown_req,
    input logic [ACC_W-1:0]  phase,
    input logic [CODE_W-1:0] dac_code,
    input logic              muted_q,
    input logic              div2_en,
    input logic              div8_en
);
    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> $stable(phase));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_en && !powerdown_req) |=> $stable(dac_code));

    // R9
    pd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        powerdown_req |=> (dac_code == '0));

    // R7
    mute_silent_chk: assert property (@(posedge clk) disable iff (rst)
        muted_q |-> (dac_code == '0));

    // R6
    div2_alt_chk: assert property (@(posedge clk) disable iff (rst)
        div2_en |=> !div2_en);

    // R6
    div8_sub_chk: assert property (@(posedge clk) disable iff (rst)
        div8_en |-> div2_en);
endmodule

bind dds_sine_core dds_sine_core_chk #(.ACC_W(dds_pkg::ACC_W), .CODE_W(dds_pkg::MAG_W + 1)) u_chk (
    .clk(clk), .rst(rst), .ref_en(ref_en), .powerdown_req(powerdown_req),
    .phase(phase), .dac_code(dac_code), .muted_q(muted_q),
    .div2_en(div2_en), .div8_en(div8_en)
);

// File: tb/dds_sine_core_bench.sv
`timescale 1ns/1ps
module dds_sine_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] word = '0;
    logic        inh = 1'b0;
    logic        pd = 1'b0;
    logic [7:0]  dac;
    logic        d2, d8;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [20:0] m_acc = '0;
    logic        m_prev = 1'b0;
    logic        m_muted = 1'b0;
    logic [7:0]  m_exp = '0;

    int n2 = 0;
    int n8 = 0;

    // word[31:16], tick count[15:0]
    localparam logic [31:0] VEC [7] = '{
        {16'h1000, 16'd512},
        {16'h0800, 16'd40},
        {16'hFFFF, 16'd70},
        {16'h0001, 16'd6},
        {16'h0000, 16'd5},
        {16'h7ABC, 16'd60},
        {16'h4000, 16'd20}
    };

    always #4 clk = ~clk;

    dds_sine_core u_dds_sine_core (
        .clk(clk), .rst(rst), .freq_word(word), .inhibit_req(inh),
        .powerdown_req(pd), .dac_code(dac), .div2_en(d2), .div8_en(d8)
    );

    always @(negedge clk) begin
        if (!rst) begin
            n2 += int'(d2);
            n8 += int'(d8);
        end
    end

    function automatic logic [7:0] code_of(input logic [20:0] a);
        logic [6:0] idx;
        real v;
        idx = a[19] ? ~a[18:12] : a[18:12];
        v = 127.0 * $sin((real'(idx) + 0.5) * 3.14159265358979 / 256.0);
        return {a[20], 7'($rtoi(v + 0.5))};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One reference tick of the requirement model (R2, R5, R7, R8, R9)
    task automatic model_step();
        logic s, mn;
        s  = m_acc[20];
        mn = (s != m_prev) ? inh : m_muted;
        m_exp = (pd || mn) ? 8'h00 : code_of(m_acc);
        m_prev = s;
        m_muted = mn;
        m_acc = m_acc + {5'b0, word};
    endtask

    task automatic run_tick(input string tag);
        repeat (4) @(negedge clk);
        model_step();
        chk(tag, dac, m_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s2, s8, nz;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dac in reset", dac, 8'h00);
        chk("R1 div2 in reset", {7'b0, d2}, 8'h00);
        chk("R1 div8 in reset", {7'b0, d8}, 8'h00);
        rst = 1'b0;

        // R6: div8 first high after the 7th edge
        repeat (7) @(negedge clk);
        chk("R6 div8 at 7th edge", {7'b0, d8}, 8'h01);
        chk("R6 div2 at 7th edge", {7'b0, d2}, 8'h01);
        @(negedge clk);
        chk("R6 div8 at 8th edge", {7'b0, d8}, 8'h00);
        model_step();
        model_step();
        chk("R1 phase-0 code", dac, 8'h01);
        chk("R5 model phase-0", dac, m_exp);

        // R6: pulse cadence over 64 clocks
        s2 = n2; s8 = n8;
        for (int i = 0; i < 16; i++) run_tick("R5 dc word");
        chk_int("R6 div2 count", n2 - s2, 32);
        chk_int("R6 div8 count", n8 - s8, 8);

        // R2 R3 R4 R5: vector table, incl. full 512-step sweep and wrap
        for (int v = 0; v < 7; v++) begin
            word = VEC[v][31:16];
            for (int t = 0; t < int'(VEC[v][15:0]); t++)
                run_tick("R2 R3 R4 vector");
        end

        // R7: inhibit waits for the sign boundary, then mutes
        word = 16'h4000;
        inh = 1'b1;
        nz = 0;
        for (int t = 0; t < 150; t++) begin
            run_tick("R7 inhibit");
            if (dac != 8'h00) nz++;
        end
        chk_int("R7 finished half cycle before mute", int'(nz > 0), 1);
        chk("R7 parked at zero", dac, 8'h00);

        // R8: release resumes only at next boundary
        inh = 1'b0;
        for (int t = 0; t < 150; t++) run_tick("R8 release");

        // R9: power-down zeroes on the next clock
        word = 16'h0800;
        for (int t = 0; t < 3; t++) run_tick("R9 pre");
        pd = 1'b1;
        @(negedge clk);
        chk("R9 zero next clock", dac, 8'h00);
        repeat (3) @(negedge clk);
        model_step();
        chk("R9 pd tick", dac, m_exp);
        s2 = n2; s8 = n8;
        for (int t = 0; t < 8; t++) run_tick("R9 held");
        chk_int("R9 div2 runs in pd", n2 - s2, 16);
        chk_int("R9 div8 runs in pd", n8 - s8, 4);
        pd = 1'b0;
        for (int t = 0; t < 20; t++) run_tick("R9 after release");

        // R1: mid-run reset clears accumulator
        word = 16'h2345;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 mid-run reset", dac, 8'h00);
        rst = 1'b0;
        m_acc = '0; m_prev = 1'b0; m_muted = 1'b0;
        run_tick("R1 first tick after reset");
        chk("R1 restart code", dac, 8'h01);
        for (int t = 0; t < 30; t++) run_tick("R2 after reset");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule